// File: doc/BRIEF.md
# Random Word Register Peripheral

This block is a memory-mapped random number source with three 32-bit registers: control, status and data. Raw 32-bit words come in from an external entropy port. That port has a word-valid strobe and a seed-fault flag. While generation is enabled, each valid word goes into a small output FIFO. Software pops words one at a time by reading the data register. The status register shows whether data is ready. It also shows the current state and the sticky flag of a clock-frequency fault and of a seed fault. The clock-fault state comes in on a pin.

A seed fault stops generation and discards buffered words. Generation stays frozen until software does two things. First it writes zero to the sticky seed flag. Then it reads the data register a fixed number of times. Those reads return zero, because their content is stale. A single interrupt line is raised for ready data or a pending fault flag, when the interrupt enable bit allows it.

Top module: `rand_word_periph`

## Requirements
- R1: After reset, the control register, the status register, the read-data output and the interrupt output are all zero.
- R2: The registers sit at byte offsets control 0x0, status 0x4 and data 0x8, and any other offset reads zero. The control register keeps only bit 2 (generation enable), bit 3 (interrupt enable) and bit 5 (clock check off), and its other bits read zero.
- R3: While generation is enabled and no seed fault is pending, each valid entropy word enters a four-word FIFO. Data reads return the words in arrival order. Words that arrive while the FIFO is full are dropped.
- R4: Status bit 0 (ready) is 1 exactly when the FIFO holds a word, generation is enabled and no seed fault is pending.
- R5: A data read while ready is 0 returns zero and changes no state.
- R6: Status bit 1 equals the clock-fault pin while control bit 5 is 0, and is 0 otherwise. Status bit 5 is a sticky flag that is set while bit 1 is 1. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R7: A seed fault while generation is enabled sets status bit 2 (seed fault current) and bit 6 (seed fault flag). It also empties the FIFO, and entropy words are ignored until recovery.
- R8: Writing 0 to status bit 6 clears it, and writing 1 leaves it unchanged.
- R9: Writing 0 to status bit 6 while bit 2 is set starts recovery. The next 12 data reads return zero. Bit 2 clears on the 12th of them, and generation then resumes. After fewer reads, bit 2 stays set.
- R10: The interrupt output goes high one clock after interrupt enable is set and at least one of status bits 0, 5 or 6 is 1. Otherwise it is low.
- R11: Clearing generation enable empties the FIFO and cancels a recovery in progress. A pending seed fault then needs a fresh 0 write to bit 6 and another 12 reads.
- R12: Writes to the data register, and writes to status bits other than 5 and 6, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, updated on each read |
| irq | output | 1 | Registered interrupt request |
| ent_valid | input | 1 | Entropy word valid |
| ent_word | input | 32 | Entropy word |
| ent_seed_fault | input | 1 | Seed fault from the entropy source |
| clk_fault | input | 1 | Clock-frequency fault state |

## Verification
Some properties are checked by assertions on every cycle:
- the FIFO occupancy never goes past its depth;
- the FIFO does not grow while a seed fault is pending;
- clearing the enable leaves the FIFO empty on the next cycle;
- a seed fault raises both seed bits;
- the recovery counter stays in range;
- data reads from an empty or stale state return zero;
- the interrupt stays low while disabled.

Other behaviour only the bench scenarios can show:
- the ordering of words and the dropping of excess words;
- the write-zero-to-clear rule of the sticky flags;
- the exact twelfth-read release of a seed fault;
- the cancellation of recovery when generation is disabled.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_DATA = 4'h8;

  localparam int CT_GEN    = 2;
  localparam int CT_IRQ    = 3;
  localparam int CT_CLKOFF = 5;

  localparam int ST_READY     = 0;
  localparam int ST_CLK_CUR   = 1;
  localparam int ST_SEED_CUR  = 2;
  localparam int ST_CLK_FLAG  = 5;
  localparam int ST_SEED_FLAG = 6;

  typedef struct packed {
    logic clk_off;
    logic irq_en;
    logic gen_en;
  } ctrl_t;
endpackage

// File: rtl/rwp_word_fifo.sv
module rwp_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign count   = cnt;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R3
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clear) |=> full); // R3
endmodule

// File: rtl/rwp_seed_guard.sv
module rwp_seed_guard #(
  parameter int FLUSH_READS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic gen_en,
  input  logic fault_ev,
  input  logic clr_req,
  input  logic data_rd,
  output logic seed_cur,
  output logic seed_flag,
  output logic stale
);
  localparam int FCW = $clog2(FLUSH_READS+1);

  logic [FCW-1:0] left;

  assign stale = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left      <= '0;
      seed_cur  <= 1'b0;
      seed_flag <= 1'b0;
    end else if (fault_ev) begin
      left      <= '0;
      seed_cur  <= 1'b1;
      seed_flag <= 1'b1;
    end else begin
      if (clr_req) seed_flag <= 1'b0;
      if (!gen_en) begin
        left <= '0;
      end else if (clr_req && seed_cur && left == '0) begin
        left <= FCW'(FLUSH_READS);
      end else if (data_rd && left != '0) begin
        left <= left - 1'b1;
        if (left == FCW'(1)) seed_cur <= 1'b0;
      end
    end
  end

  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (rst)
    left <= FCW'(FLUSH_READS)); // R9
  AST_SEED_BITS_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_ev |=> (seed_cur && seed_flag)); // R7
  AST_FLUSH_ONLY_WHEN_CUR: assert property (@(posedge clk) disable iff (rst)
    stale |-> seed_cur); // R9
endmodule

// File: rtl/rand_word_periph.sv
module rand_word_periph
  import rwp_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int FLUSH_READS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  input  logic              ent_valid,
  input  logic [REG_W-1:0]  ent_word,
  input  logic              ent_seed_fault,
  input  logic              clk_fault
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  ctrl_t ctl;
  logic clk_flag;
  logic wr_ctrl, wr_stat, rd_data;
  logic fault_ev, seed_clr;
  logic seed_cur, seed_flag, stale;
  logic fifo_clear, fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [REG_W-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic ready, clk_cur;
  logic [REG_W-1:0] ctrl_view, stat_view;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata[REG_W-1:7], bus_wdata[4:0], fifo_full};

  assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_stat = bus_wr && (bus_addr == OFF_STAT);
  assign rd_data = bus_rd && (bus_addr == OFF_DATA);

  assign clk_cur  = clk_fault && !ctl.clk_off;
  assign fault_ev = ctl.gen_en && ent_seed_fault;
  assign seed_clr = wr_stat && !bus_wdata[ST_SEED_FLAG];
  assign ready    = !fifo_empty && ctl.gen_en && !seed_cur;

  assign fifo_clear = !ctl.gen_en || fault_ev;
  assign fifo_push  = ctl.gen_en && !seed_cur && ent_valid && !ent_seed_fault;
  assign fifo_pop   = rd_data && ready;

  rwp_word_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .clear(fifo_clear),
    .push(fifo_push), .push_word(ent_word), .pop(fifo_pop),
    .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  rwp_seed_guard #(.FLUSH_READS(FLUSH_READS)) guard_i (
    .clk(clk), .rst(rst), .gen_en(ctl.gen_en), .fault_ev(fault_ev),
    .clr_req(seed_clr), .data_rd(rd_data),
    .seed_cur(seed_cur), .seed_flag(seed_flag), .stale(stale)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CT_GEN]    = ctl.gen_en;
    ctrl_view[CT_IRQ]    = ctl.irq_en;
    ctrl_view[CT_CLKOFF] = ctl.clk_off;
    stat_view = '0;
    stat_view[ST_READY]     = ready;
    stat_view[ST_CLK_CUR]   = clk_cur;
    stat_view[ST_SEED_CUR]  = seed_cur;
    stat_view[ST_CLK_FLAG]  = clk_flag;
    stat_view[ST_SEED_FLAG] = seed_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      clk_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl.gen_en  <= bus_wdata[CT_GEN];
        ctl.irq_en  <= bus_wdata[CT_IRQ];
        ctl.clk_off <= bus_wdata[CT_CLKOFF];
      end
      if (clk_cur) clk_flag <= 1'b1;
      else if (wr_stat && !bus_wdata[ST_CLK_FLAG]) clk_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ctl.irq_en && (ready || clk_flag || seed_flag);
      if (bus_rd) begin
        unique case (bus_addr)
          OFF_CTRL: bus_rdata <= ctrl_view;
          OFF_STAT: bus_rdata <= stat_view;
          OFF_DATA: bus_rdata <= (ready && !stale) ? fifo_head : '0;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_NO_GROWTH_IN_SEED: assert property (@(posedge clk) disable iff (rst)
    seed_cur |=> (fifo_cnt <= $past(fifo_cnt))); // R7
  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !ctl.gen_en |=> fifo_empty); // R11
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data && (fifo_empty || stale)) |=> (bus_rdata == '0)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctl.irq_en |=> !irq); // R10
endmodule

// File: tb/rand_word_periph_tb_top.sv
module rand_word_periph_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] word;
    logic        kept;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{32'hA5A5_0001, 1'b1}, '{32'h1234_5678, 1'b1}, '{32'hDEAD_BEEF, 1'b1},
    '{32'h0F0F_F0F0, 1'b1}, '{32'h7777_0005, 1'b0}, '{32'h8888_0006, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, ent_word = '0, rd_val;
  logic irq, ent_valid = 1'b0, ent_seed_fault = 1'b0, clk_fault = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rand_word_periph dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ent_valid(ent_valid), .ent_word(ent_word),
    .ent_seed_fault(ent_seed_fault), .clk_fault(clk_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; rd_val = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); ent_valid = 1'b1; ent_word = w;
    @(negedge clk); ent_valid = 1'b0;
  endtask

  task automatic seed_fault();
    @(negedge clk); ent_seed_fault = 1'b1;
    @(negedge clk); ent_seed_fault = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(4'h0); chk("R1 ctrl", rd_val, 32'd0);
    rd(4'h4); chk("R1 status", rd_val, 32'd0);

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0); chk("R2 ctrl mask", rd_val, 32'h0000_002C);
    wr(4'h0, 32'h0000_0004);
    rd(4'hC); chk("R2 unmapped", rd_val, 32'd0);
    rd(4'h8); chk("R5 empty read", rd_val, 32'd0);
    rd(4'h4); chk("R5 status unchanged", rd_val, 32'd0);

    foreach (VEC[i]) push(VEC[i].word);
    foreach (VEC[i]) begin
      if (VEC[i].kept) begin
        rd(4'h8); chk("R3 fifo order", rd_val, VEC[i].word);
      end
    end
    rd(4'h8); chk("R3 overflow dropped", rd_val, 32'd0);

    push(32'hCAFE_0001);
    rd(4'h4); chk("R4 ready set", rd_val, 32'h0000_0001);
    wr(4'h8, 32'h1111_1111);
    wr(4'h4, 32'hFFFF_FF9F);
    rd(4'h4); chk("R12 no effect", rd_val, 32'h0000_0001);
    wr(4'h0, 32'h0);
    rd(4'h4); chk("R4 ready off when disabled", rd_val, 32'd0);
    wr(4'h0, 32'h4);
    rd(4'h8); chk("R11 fifo emptied", rd_val, 32'd0);

    clk_fault = 1'b1;
    rd(4'h4); chk("R6 clk cur and flag", rd_val, 32'h0000_0022);
    clk_fault = 1'b0;
    rd(4'h4); chk("R6 flag sticky", rd_val, 32'h0000_0020);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4); chk("R6 write one keeps", rd_val, 32'h0000_0020);
    wr(4'h4, 32'h0);
    rd(4'h4); chk("R6 write zero clears", rd_val, 32'd0);
    wr(4'h0, 32'h24);
    clk_fault = 1'b1;
    rd(4'h4); chk("R6 check off", rd_val, 32'd0);
    clk_fault = 1'b0;

    wr(4'h0, 32'h0C);
    @(negedge clk); chk("R10 irq idle", {31'd0, irq}, 32'd0);
    push(32'hBEEF_0002);
    @(negedge clk); chk("R10 irq on ready", {31'd0, irq}, 32'd1);
    rd(4'h8); chk("R3 single word", rd_val, 32'hBEEF_0002);
    @(negedge clk); chk("R10 irq drops", {31'd0, irq}, 32'd0);
    wr(4'h0, 32'h04);

    push(32'h5555_0003);
    seed_fault();
    rd(4'h4); chk("R7 seed bits", rd_val, 32'h0000_0044);
    push(32'h6666_0004);
    rd(4'h4); chk("R7 ignored word", rd_val, 32'h0000_0044);
    wr(4'h4, 32'h0000_0040);
    rd(4'h4); chk("R8 write one keeps", rd_val, 32'h0000_0044);
    wr(4'h4, 32'h0);
    rd(4'h4); chk("R8 flag cleared", rd_val, 32'h0000_0004);
    for (int k = 0; k < 11; k++) begin
      rd(4'h8); chk("R9 stale zero", rd_val, 32'd0);
    end
    rd(4'h4); chk("R9 still held", rd_val, 32'h0000_0004);
    rd(4'h8); chk("R9 twelfth read", rd_val, 32'd0);
    rd(4'h4); chk("R9 released", rd_val, 32'd0);
    push(32'h9999_0007);
    rd(4'h8); chk("R9 resumed", rd_val, 32'h9999_0007);

    seed_fault();
    wr(4'h4, 32'h0);
    for (int k = 0; k < 5; k++) rd(4'h8);
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h4);
    for (int k = 0; k < 7; k++) rd(4'h8);
    rd(4'h4); chk("R11 recovery cancelled", rd_val, 32'h0000_0004);
    wr(4'h4, 32'h0);
    for (int k = 0; k < 12; k++) rd(4'h8);
    rd(4'h4); chk("R11 fresh recovery", rd_val, 32'd0);

    summary();
  end
endmodule